// File: doc/BRIEF.md
# ASCII-Hex Serial Frame Receiver with Sum Check

This block takes in a serial-protocol frame written as printable ASCII, one character per accepted transfer on a valid/ready byte stream. It waits for a colon to open a frame. It then turns each pair of hex digits into one byte and forwards the decoded station address, command and payload bytes on an output stream, with each byte tagged by its role. The receiver also keeps a running modulo-256 sum of every decoded byte. The last pair before the carriage return is the frame's check byte: it is added to the sum but is never forwarded. Once the line-feed that closes the frame arrives, a one-cycle status pulse reports whether the frame is good, or what went wrong with it.

It sits between a character-level UART receiver and a command decoder. The command decoder consumes the tagged bytes and takes the status pulse as the end-of-frame marker. Backpressure on the output stream stalls the character input.

Top module: `hexframe_rx`

## Requirements
- R1: Characters received outside a frame, before any colon (3AH) or after a frame has ended or been rejected, produce neither output bytes nor a status pulse.
- R2: Each byte is decoded from two hex digits, high nibble first. Forwarded bytes carry out_kind 0 for the first byte (address), 1 for the second (command) and 2 for every later payload byte. The final decoded byte (the check) is never forwarded.
- R3: The lowercase digits a-f decode to the same values as A-F.
- R4: At the LF (0AH) that follows CR (0DH), the status reports good when the modulo-256 sum of all decoded bytes, check included, is 00H. Otherwise it sets stat_lrc_err. For example, bytes 01 03 10 00 00 02 take check EAH.
- R5: stat_fmt_err is reported on the offending character, with no other error flag, and the receiver then ignores everything up to the next colon. It is raised for: a non-hex character where a digit is expected; CR after a lone high nibble; any character other than LF after CR; or a frame of fewer than three bytes.
- R6: If the second byte is not 02H, 03H, 05H or 06H, a frame that otherwise completes reports stat_cmd_err and is not good.
- R7: A colon received in the middle of a frame discards the bytes still held back and restarts decoding with a fresh sum and byte count.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_kind hold steady, and in_ready is low.
- R9: stat_valid is a single-cycle pulse, registered on the edge that accepts the closing LF or the offending character. stat_good is never set together with an error flag, and no flag is set without stat_valid.
- R10: After reset, out_valid and stat_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input character valid |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted when high with in_valid |
| out_valid | output | 1 | Decoded byte valid |
| out_ready | input | 1 | Downstream accepts the decoded byte |
| out_data | output | 8 | Decoded byte |
| out_kind | output | 2 | Byte role: 0 address, 1 command, 2 payload |
| stat_valid | output | 1 | One-cycle end-of-frame status strobe |
| stat_good | output | 1 | Frame complete with correct sum and known command |
| stat_fmt_err | output | 1 | Framing or character error |
| stat_lrc_err | output | 1 | Sum of bytes including check is not zero |
| stat_cmd_err | output | 1 | Command byte not in the accepted set |

## Verification
A wrong decoder state shows up at the ports within one character. A digit taken as the wrong nibble changes the byte forwarded on the next pair. A missed or extra state transition turns a good frame into a format error at its CR or LF. A corrupted running sum or byte counter stays hidden until the closing LF, where it flips the good or error flags. Faults in the hold-back register show up as a missing, extra or mistagged byte one pair later than the fault. The scoreboard therefore compares every forwarded byte and every status pulse in order, and it flags any item the design emits that is not expected.

// File: rtl/hexframe_pkg.sv
package hexframe_pkg;

  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_DATA = 2'd2
  } byte_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_LF   = 2'd3
  } rx_state_e;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == 8'h02) || (c == 8'h03) || (c == 8'h05) || (c == 8'h06);
  endfunction

endpackage

// File: rtl/hexframe_char_dec.sv
module hexframe_char_dec
  import hexframe_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] nib,
  output logic       is_colon,
  output logic       is_cr,
  output logic       is_lf
);

  always_comb begin
    is_hex = 1'b0;
    nib    = 4'h0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      is_hex = 1'b1;
      nib    = 4'(ch - 8'h30);
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      is_hex = 1'b1;
      nib    = 4'(ch - 8'h37);
    end else if (ch >= 8'h61 && ch <= 8'h66) begin
      is_hex = 1'b1;
      nib    = 4'(ch - 8'h57);
    end
    is_colon = (ch == CH_COLON);
    is_cr    = (ch == CH_CR);
    is_lf    = (ch == CH_LF);
  end

endmodule

// File: rtl/hexframe_lrc.sv
module hexframe_lrc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         add,
  input  logic [W-1:0] din,
  output logic [W-1:0] sum
);

  always_ff @(posedge clk) begin
    if (rst || clear) sum <= '0;
    else if (add)     sum <= sum + din;
  end

endmodule

// File: rtl/hexframe_holdback.sv
module hexframe_holdback
  import hexframe_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [W-1:0]     din,
  output logic             held_valid,
  output logic [W-1:0]     held_data,
  output byte_kind_e       held_kind,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held_valid <= 1'b0;
      held_data  <= '0;
      held_kind  <= KIND_ADDR;
      count      <= '0;
    end else if (load) begin
      held_valid <= 1'b1;
      held_data  <= din;
      if (count == '0)      held_kind <= KIND_ADDR;
      else if (count == 1)  held_kind <= KIND_CMD;
      else                  held_kind <= KIND_DATA;
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/hexframe_rx.sv
module hexframe_rx
  import hexframe_pkg::*;
#(
  parameter int W         = 8,
  parameter int CNT_W     = 8,
  parameter int MIN_BYTES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [7:0]   in_char,
  output logic         in_ready,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic [1:0]   out_kind,
  output logic         stat_valid,
  output logic         stat_good,
  output logic         stat_fmt_err,
  output logic         stat_lrc_err,
  output logic         stat_cmd_err
);

  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_BYTES);

  rx_state_e        state;
  logic             fire;
  logic             is_hex, is_colon, is_cr, is_lf;
  logic [3:0]       nib, hi_nib;
  logic             start, byte_done, emit, fmt_now, end_ok;
  logic [W-1:0]     new_byte, sum, held_data, cmd_byte;
  logic             held_valid;
  byte_kind_e       held_kind;
  logic [CNT_W-1:0] byte_cnt;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  hexframe_char_dec u_dec (
    .ch       (in_char),
    .is_hex   (is_hex),
    .nib      (nib),
    .is_colon (is_colon),
    .is_cr    (is_cr),
    .is_lf    (is_lf)
  );

  assign new_byte  = {hi_nib, nib};
  assign start     = fire && is_colon;
  assign byte_done = fire && !is_colon && (state == ST_LO) && is_hex;
  assign emit      = byte_done && held_valid;

  always_comb begin
    fmt_now = 1'b0;
    end_ok  = 1'b0;
    if (fire && !is_colon) begin
      unique case (state)
        ST_HI:   fmt_now = !is_hex && !is_cr;
        ST_LO:   fmt_now = !is_hex;
        ST_LF: begin
          fmt_now = !is_lf || (byte_cnt < MIN_CNT);
          end_ok  = is_lf && (byte_cnt >= MIN_CNT);
        end
        default: ;
      endcase
    end
  end

  hexframe_lrc #(.W(W)) u_lrc (
    .clk   (clk),
    .rst   (rst),
    .clear (start),
    .add   (byte_done),
    .din   (new_byte),
    .sum   (sum)
  );

  hexframe_holdback #(.W(W), .CNT_W(CNT_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .clear      (start),
    .load       (byte_done),
    .din        (new_byte),
    .held_valid (held_valid),
    .held_data  (held_data),
    .held_kind  (held_kind),
    .count      (byte_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hi_nib   <= '0;
      cmd_byte <= '0;
    end else if (start) begin
      state <= ST_HI;
    end else if (fire) begin
      unique case (state)
        ST_IDLE: state <= ST_IDLE;
        ST_HI: begin
          if (is_hex) begin
            hi_nib <= nib;
            state  <= ST_LO;
          end else if (is_cr) begin
            state <= ST_LF;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_LO: begin
          if (is_hex) begin
            state <= ST_HI;
            if (byte_cnt == 1) cmd_byte <= new_byte;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid   <= 1'b0;
      stat_good    <= 1'b0;
      stat_fmt_err <= 1'b0;
      stat_lrc_err <= 1'b0;
      stat_cmd_err <= 1'b0;
    end else begin
      stat_valid   <= fmt_now || end_ok;
      stat_fmt_err <= fmt_now;
      stat_lrc_err <= end_ok && (sum != '0);
      stat_cmd_err <= end_ok && !cmd_known(cmd_byte);
      stat_good    <= end_ok && (sum == '0) && cmd_known(cmd_byte);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_kind  <= KIND_ADDR;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= held_data;
      out_kind  <= held_kind;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/hexframe_rx_chk.sv
module hexframe_rx_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic [1:0]   out_kind,
  input logic         stat_valid,
  input logic         stat_good,
  input logic         stat_fmt_err,
  input logic         stat_lrc_err,
  input logic         stat_cmd_err
);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_kind));

  p_good_excl_r9: assert property (@(posedge clk) disable iff (rst)
    stat_valid && stat_good |-> !stat_fmt_err && !stat_lrc_err && !stat_cmd_err);

  p_flags_need_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !stat_valid |-> !stat_good && !stat_fmt_err && !stat_lrc_err && !stat_cmd_err);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid);

  p_fmt_alone_r5: assert property (@(posedge clk) disable iff (rst)
    stat_valid && stat_fmt_err |-> !stat_lrc_err && !stat_cmd_err);

  p_quiet_after_end_r1: assert property (@(posedge clk) disable iff (rst)
    stat_valid && !out_valid |=> !out_valid);

  p_kind_range_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_kind != 2'd3);

  p_stall_blocks_input_r8: assert property (@(posedge clk) disable iff (rst)
    $past(out_valid) && !$past(out_ready) && $past(!rst) |-> out_valid);

endmodule

bind hexframe_rx hexframe_rx_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_kind     (out_kind),
  .stat_valid   (stat_valid),
  .stat_good    (stat_good),
  .stat_fmt_err (stat_fmt_err),
  .stat_lrc_err (stat_lrc_err),
  .stat_cmd_err (stat_cmd_err)
);

// File: tb/hexframe_rx_tb_top.sv
module hexframe_rx_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic [1:0] out_kind;
  logic       stat_valid, stat_good, stat_fmt_err, stat_lrc_err, stat_cmd_err;

  int errors = 0;
  int checks = 0;
  bit stall_mode = 1'b0;
  int stall_cnt = 0;

  logic [9:0] exp_out[$];   // {kind, data}
  logic [3:0] exp_stat[$];  // {good, fmt, lrc, cmd}

  always #(CLK_PERIOD/2) clk = ~clk;

  hexframe_rx dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_kind(out_kind),
    .stat_valid(stat_valid), .stat_good(stat_good), .stat_fmt_err(stat_fmt_err),
    .stat_lrc_err(stat_lrc_err), .stat_cmd_err(stat_cmd_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // output-ready pattern, changed just after the rising edge
  always @(posedge clk) begin
    #1;
    stall_cnt++;
    out_ready = !stall_mode || (stall_cnt % 4 == 0);
  end

  // scoreboard monitor
  logic       prev_stall = 1'b0;
  logic [9:0] prev_item = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(out_valid && {out_kind, out_data} == prev_item, "R8", "held byte",
              {5'd0, out_valid, out_kind, out_data}, {6'd1, prev_item});
      if (out_valid && !out_ready)
        check(!in_ready, "R8", "in_ready during stall", 16'(in_ready), 16'd0);
      prev_stall = out_valid && !out_ready;
      prev_item  = {out_kind, out_data};
      if (out_valid && out_ready) begin
        if (exp_out.size() == 0)
          check(1'b0, "R1", "unexpected byte", {6'd0, out_kind, out_data}, 16'h0);
        else begin
          logic [9:0] e;
          e = exp_out.pop_front();
          check({out_kind, out_data} == e, "R2", "byte", {6'd0, out_kind, out_data}, {6'd0, e});
        end
      end
      if (stat_valid) begin
        logic [3:0] a;
        a = {stat_good, stat_fmt_err, stat_lrc_err, stat_cmd_err};
        if (exp_stat.size() == 0)
          check(1'b0, "R9", "unexpected status", 16'(a), 16'h0);
        else begin
          logic [3:0] e;
          e = exp_stat.pop_front();
          check(a == e, "R4", "status {good,fmt,lrc,cmd}", 16'(a), 16'(e));
        end
      end
    end
  end

  task automatic send_char(input logic [7:0] c);
    bit done = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    while (!done) begin
      done = in_ready;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  function automatic logic [7:0] hex_ch(input logic [3:0] n, input bit lower);
    if (n < 10) return 8'h30 + 8'(n);
    return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit lower);
    send_char(hex_ch(b[7:4], lower));
    send_char(hex_ch(b[3:0], lower));
  endtask

  function automatic logic [1:0] kind_of(input int i);
    return (i == 0) ? 2'd0 : (i == 1) ? 2'd1 : 2'd2;
  endfunction

  // full frame: bytes then computed check (optionally corrupted)
  task automatic send_frame(input logic [7:0] b[$], input bit lower, input bit bad_chk);
    logic [7:0] s = 8'h00;
    logic [7:0] chk;
    bit known;
    foreach (b[i]) begin
      s += b[i];
      exp_out.push_back({kind_of(i), b[i]});
    end
    chk = 8'h00 - s;
    if (bad_chk) chk ^= 8'h01;
    known = (b[1] == 8'h02) || (b[1] == 8'h03) || (b[1] == 8'h05) || (b[1] == 8'h06);
    exp_stat.push_back({!bad_chk && known, 1'b0, bad_chk, !known});
    send_char(8'h3A);
    foreach (b[i]) send_byte(b[i], lower);
    send_byte(chk, lower);
    send_char(8'h0D);
    send_char(8'h0A);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_out.size() != 0 || exp_stat.size() != 0) && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(exp_out.size() == 0, "R2", "bytes still pending", 16'(exp_out.size()), 16'd0);
    check(exp_stat.size() == 0, "R9", "status still pending", 16'(exp_stat.size()), 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] f[$];
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!out_valid, "R10", "out_valid after reset", 16'(out_valid), 16'd0);
    check(!stat_valid, "R10", "stat_valid after reset", 16'(stat_valid), 16'd0);
    check(in_ready, "R10", "in_ready after reset", 16'(in_ready), 16'd1);

    // R1: noise before colon ignored, then R2/R4 reference frame (check EA)
    send_str("12AB");
    send_char(8'h0D); send_char(8'h0A);
    f = '{8'h01, 8'h03, 8'h10, 8'h00, 8'h00, 8'h02};
    send_frame(f, 1'b0, 1'b0);
    drain();

    // R3 lowercase digits
    f = '{8'hAB, 8'h06, 8'hCD, 8'hEF, 8'h5A};
    send_frame(f, 1'b1, 1'b0);
    drain();

    // R4 bad check
    f = '{8'h11, 8'h05, 8'h08, 8'h10};
    send_frame(f, 1'b0, 1'b1);
    drain();

    // R6 unknown command, minimal frame
    f = '{8'h01, 8'h07};
    send_frame(f, 1'b0, 1'b0);
    drain();

    // R5 non-hex character in frame; later garbage ignored (R1)
    exp_out.push_back({2'd0, 8'h01});
    exp_stat.push_back(4'b0100);
    send_str(":0103G");
    send_str("12");
    send_char(8'h0D); send_char(8'h0A);
    drain();

    // R5 odd digit count (CR after lone high nibble)
    exp_out.push_back({2'd0, 8'h01});
    exp_stat.push_back(4'b0100);
    send_str(":01031");
    send_char(8'h0D);
    drain();

    // R5 CR not followed by LF
    exp_out.push_back({2'd0, 8'h01});
    exp_out.push_back({2'd1, 8'h03});
    exp_stat.push_back(4'b0100);
    send_str(":0103FC");
    send_char(8'h0D);
    send_char(8'h58);
    drain();

    // R5 frame too short (two bytes summing to zero)
    exp_out.push_back({2'd0, 8'h01});
    exp_stat.push_back(4'b0100);
    send_str(":01FF");
    send_char(8'h0D); send_char(8'h0A);
    drain();

    // R7 colon mid-frame restarts decoding
    exp_out.push_back({2'd0, 8'h22});
    send_str(":2203");
    f = '{8'h02, 8'h03, 8'h00, 8'h44};
    send_frame(f, 1'b0, 1'b0);
    drain();

    // R8 backpressure on the output stream
    stall_mode = 1'b1;
    f = '{8'h7E, 8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    send_frame(f, 1'b0, 1'b0);
    drain();
    stall_mode = 1'b0;
    f = '{8'h09, 8'h02, 8'h80};
    send_frame(f, 1'b1, 1'b0);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule